// File: doc/BRIEF.md
# Serial Control Port with Register and Memory Readback

This block is the slave end of a four-wire serial control link for a signal-processing device. A host frames each transaction by pulling the active-low select low. It then clocks in a 16-bit command header followed by one or more 24-bit data words. The header holds five must-be-zero pad bits, a direction bit and a 10-bit word address. The address falls into one of three regions: a parameter memory, a program memory or a bank of control registers.

On a write, each completed data word raises a one-cycle write strobe toward the region that owns the current address. The strobe comes with that address and the word. On a read, the port fetches the addressed word from the region's read port once the header is complete. It then shifts the word out MSB first on the serial output, whose output enable stays low until the data phase begins. Words that follow within the same frame use consecutive addresses. The serial pins are oversampled by the system clock, so the whole block lives in one clock domain.

The control machine has six states:
- IDLE waits for select to fall and moves to HEADER.
- HEADER gathers 16 bits. After the last bit it moves to SKIP (pad bits not zero), FETCH (read) or DATA (write).
- FETCH loads read data into the output shifter, then moves to DATA.
- DATA gathers 24 bits. After the last bit it moves to COMMIT (write) or back to FETCH with the next address (read).
- COMMIT issues the strobe, advances the address and returns to DATA.
- SKIP waits out a rejected frame.

Select going high sends every state to IDLE.

Top module: `ctl_serial_port`

## Requirements
- R1: While spi_cs_n is low, spi_mosi is sampled on each rising spi_sclk edge, MSB first. The 16-bit header reads: bits 15..11 pad (zero), bit 10 direction (1 = read, 0 = write), bits 9..0 word address.
- R2: A header whose pad bits are not all zero rejects the frame until select rises. A rejected frame raises no write strobe, and spi_miso_oe stays low.
- R3: In a write frame, once all 24 bits of a data word (MSB first) are received, exactly one write strobe pulses for one clk cycle. The strobe carries tgt_addr equal to the word's address and tgt_wdata equal to the word.
- R4: Address decode: 0x000 to 0x1FF raises par_we; 0x200 to 0x37F raises prg_we; 0x380 to 0x3FF raises reg_we. At most one strobe is high in any cycle.
- R5: Each additional 24-bit word in a write frame is written to the previous address plus one, wrapping from 0x3FF to 0x000.
- R6: A data word cut short by select rising before its 24th bit is discarded, with no strobe. The next frame works normally.
- R7: In a read frame, spi_miso_oe is low during all 16 header bits. It is high from the end of the header until select rises. Bit 23 of the word is on spi_miso before the first data rising edge, and each later bit appears after a falling spi_sclk edge.
- R8: Each further 24-bit word clocked within a read frame returns the data of the previous address plus one. The returned data comes from the region that owns that address.
- R9: Within a few clk cycles after select rises, spi_miso_oe is low. spi_miso is 0 whenever spi_miso_oe is low.
- R10: After reset, all strobes are low, spi_miso_oe is low and spi_miso is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial pins are oversampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_miso | output | 1 | Serial read data |
| spi_miso_oe | output | 1 | Output enable for the serial read pin (high = drive) |
| tgt_addr | output | 10 | Word address toward the targets |
| tgt_wdata | output | 24 | Write data toward the targets |
| par_we | output | 1 | Parameter-memory write strobe |
| prg_we | output | 1 | Program-memory write strobe |
| reg_we | output | 1 | Control-register write strobe |
| par_rdata | input | 24 | Parameter-memory read data for tgt_addr (combinational) |
| prg_rdata | input | 24 | Program-memory read data for tgt_addr (combinational) |
| reg_rdata | input | 24 | Control-register read data for tgt_addr (combinational) |

## Verification
The bench aims at the region boundaries 0x1FF/0x200, 0x37F/0x380 and the top address 0x3FF. A decoder off by one there would strobe the wrong target. A continuous write across 0x3FF checks the wrap to 0x000, and a continuous read across 0x37F/0x380 checks that each prefetched word is fetched from the new region. An early prefetch would return stale data, and a late one would lose bit 23. A frame cut mid-word and frames with a set pad bit check that no strobe and no output drive leak out. The output enable is sampled during the header, where a premature enable would show.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;
    typedef enum logic [1:0] {
        RGN_PARAM = 2'd0,
        RGN_PROG  = 2'd1,
        RGN_CTRL  = 2'd2
    } region_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HEADER = 3'd1,
        ST_FETCH  = 3'd2,
        ST_DATA   = 3'd3,
        ST_COMMIT = 3'd4,
        ST_SKIP   = 3'd5
    } port_state_t;
endpackage

// File: rtl/ctl_spi_sync.sv
module ctl_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic mosi_i,
    input  logic csn_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic mosi_o,
    output logic csn_o
);
    // lane order {csn, sclk, mosi}; select idles high
    localparam logic [2:0] IDLE_V = 3'b100;

    logic [2:0] pipe [STAGES];
    logic       sclk_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= IDLE_V;
                    else        pipe[0] <= {csn_i, sclk_i, mosi_i};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= IDLE_V;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= pipe[STAGES-1][1];
    end

    assign csn_o       = pipe[STAGES-1][2];
    assign mosi_o      = pipe[STAGES-1][0];
    assign sclk_rise_o = pipe[STAGES-1][1] & ~sclk_prev;
    assign sclk_fall_o = ~pipe[STAGES-1][1] & sclk_prev;
endmodule

// File: rtl/ctl_region_decode.sv
module ctl_region_decode
    import ctl_serial_pkg::*;
#(
    parameter int          ADDR_W   = 10,
    parameter logic [9:0]  PRG_BASE = 10'h200,
    parameter logic [9:0]  REG_BASE = 10'h380
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_t           region_o
);
    always_comb begin
        if (addr_i < ADDR_W'(PRG_BASE))      region_o = RGN_PARAM;
        else if (addr_i < ADDR_W'(REG_BASE)) region_o = RGN_PROG;
        else                                 region_o = RGN_CTRL;
    end
endmodule

// File: rtl/ctl_tx_shift.sv
module ctl_tx_shift #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              shift_i,
    output logic              bit_o
);
    logic [DATA_W-1:0] sr_q;
    logic              fresh_q;

    // a freshly loaded word already shows its MSB, so the first
    // falling edge after a load keeps it instead of shifting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= '0;
            fresh_q <= 1'b0;
        end else if (clr_i) begin
            sr_q    <= '0;
            fresh_q <= 1'b0;
        end else if (load_i) begin
            sr_q    <= load_data_i;
            fresh_q <= 1'b1;
        end else if (shift_i) begin
            if (fresh_q) fresh_q <= 1'b0;
            else         sr_q    <= {sr_q[DATA_W-2:0], 1'b0};
        end
    end

    assign bit_o = sr_q[DATA_W-1];

    assert_load_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> (bit_o == $past(load_data_i[DATA_W-1])));
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
    import ctl_serial_pkg::*;
#(
    parameter int         ADDR_W      = 10,
    parameter int         DATA_W      = 24,
    parameter int         PAD_W       = 5,
    parameter int         SYNC_STAGES = 2,
    parameter logic [9:0] PRG_BASE    = 10'h200,
    parameter logic [9:0] REG_BASE    = 10'h380
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic              par_we,
    output logic              prg_we,
    output logic              reg_we,
    input  logic [DATA_W-1:0] par_rdata,
    input  logic [DATA_W-1:0] prg_rdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int HDR_W   = PAD_W + 1 + ADDR_W;
    localparam int MAX_W   = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int CNT_W   = $clog2(MAX_W);
    localparam int RNW_BIT = ADDR_W;

    logic csn_s, mosi_s, sclk_rise, sclk_fall;

    ctl_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (spi_sclk),
        .mosi_i      (spi_mosi),
        .csn_i       (spi_cs_n),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall),
        .mosi_o      (mosi_s),
        .csn_o       (csn_s)
    );

    port_state_t       state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-1:0] in_sr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              rnw_q;
    logic              oe_q;

    logic [HDR_W-1:0]  hdr_full;
    logic [DATA_W-1:0] word_full;
    logic              hdr_last, word_last, hdr_bad;

    assign hdr_full  = {in_sr_q[HDR_W-2:0], mosi_s};
    assign word_full = {in_sr_q[DATA_W-2:0], mosi_s};
    assign hdr_bad   = |hdr_full[HDR_W-1 -: PAD_W];
    assign hdr_last  = sclk_rise && (bit_cnt_q == CNT_W'(HDR_W - 1));
    assign word_last = sclk_rise && (bit_cnt_q == CNT_W'(DATA_W - 1));

    region_t region;

    ctl_region_decode #(
        .ADDR_W   (ADDR_W),
        .PRG_BASE (PRG_BASE),
        .REG_BASE (REG_BASE)
    ) u_decode (
        .addr_i   (addr_q),
        .region_o (region)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!csn_s) state_d = ST_HEADER;
            ST_HEADER: begin
                if (csn_s)                         state_d = ST_IDLE;
                else if (hdr_last && hdr_bad)      state_d = ST_SKIP;
                else if (hdr_last && hdr_full[RNW_BIT]) state_d = ST_FETCH;
                else if (hdr_last)                 state_d = ST_DATA;
            end
            ST_FETCH:  state_d = csn_s ? ST_IDLE : ST_DATA;
            ST_DATA: begin
                if (csn_s)          state_d = ST_IDLE;
                else if (word_last) state_d = rnw_q ? ST_FETCH : ST_COMMIT;
            end
            ST_COMMIT: state_d = csn_s ? ST_IDLE : ST_DATA;
            ST_SKIP:   if (csn_s) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            in_sr_q   <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            rnw_q     <= 1'b0;
            oe_q      <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                bit_cnt_q <= '0;
            end else if (sclk_rise && (state_q == ST_HEADER || state_q == ST_DATA)) begin
                in_sr_q <= word_full;
                if (hdr_last && state_q == ST_HEADER)    bit_cnt_q <= '0;
                else if (word_last && state_q == ST_DATA) bit_cnt_q <= '0;
                else                                     bit_cnt_q <= bit_cnt_q + 1'b1;
            end

            if (state_q == ST_HEADER && hdr_last && !hdr_bad && !csn_s) begin
                addr_q <= hdr_full[ADDR_W-1:0];
                rnw_q  <= hdr_full[RNW_BIT];
            end
            if (state_q == ST_DATA && word_last && !csn_s) begin
                wdata_q <= word_full;
                if (rnw_q) addr_q <= addr_q + 1'b1;
            end
            if (state_q == ST_COMMIT) addr_q <= addr_q + 1'b1;

            if (csn_s)                      oe_q <= 1'b0;
            else if (state_q == ST_FETCH)   oe_q <= 1'b1;
        end
    end

    // output logic
    logic              tx_bit, tx_load, tx_clr, tx_shift;
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        par_we   = 1'b0;
        prg_we   = 1'b0;
        reg_we   = 1'b0;
        rd_word  = '0;
        unique case (region)
            RGN_PARAM: begin par_we = (state_q == ST_COMMIT); rd_word = par_rdata; end
            RGN_PROG:  begin prg_we = (state_q == ST_COMMIT); rd_word = prg_rdata; end
            RGN_CTRL:  begin reg_we = (state_q == ST_COMMIT); rd_word = reg_rdata; end
            default:   ;
        endcase
        tx_load     = (state_q == ST_FETCH);
        tx_clr      = (state_q == ST_IDLE);
        tx_shift    = sclk_fall && oe_q;
        tgt_addr    = addr_q;
        tgt_wdata   = wdata_q;
        spi_miso_oe = oe_q;
        spi_miso    = oe_q & tx_bit;
    end

    ctl_tx_shift #(.DATA_W(DATA_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (tx_clr),
        .load_i      (tx_load),
        .load_data_i (rd_word),
        .shift_i     (tx_shift),
        .bit_o       (tx_bit)
    );

    assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({par_we, prg_we, reg_we}));

    assert_commit_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (par_we || prg_we || reg_we) |=> (tgt_addr == $past(tgt_addr) + 1'b1));

    assert_oe_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> rnw_q);

    assert_oe_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csn_s) |=> !spi_miso_oe);

    assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> (!spi_miso_oe && !par_we && !prg_we && !reg_we));

    assert_miso_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_oe |-> !spi_miso);
endmodule

// File: tb/ctl_serial_port_test.sv
module ctl_serial_port_test;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
    logic        spi_miso, spi_miso_oe;
    logic [9:0]  tgt_addr;
    logic [23:0] tgt_wdata;
    logic        par_we, prg_we, reg_we;
    logic [23:0] par_rdata, prg_rdata, reg_rdata;

    always #10 clk = ~clk;

    ctl_serial_port uut (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .par_we(par_we), .prg_we(prg_we), .reg_we(reg_we),
        .par_rdata(par_rdata), .prg_rdata(prg_rdata), .reg_rdata(reg_rdata)
    );

    // target read ports: each region returns a tagged copy of the address
    always_comb begin
        par_rdata = {8'hA1, 6'h0, tgt_addr};
        prg_rdata = {8'hB2, 6'h0, tgt_addr};
        reg_rdata = {8'hC3, 6'h0, tgt_addr};
    end

    // region codes used by the bench: 0 parameter, 1 program, 2 control
    function automatic int rgn_of(input logic [9:0] a);
        if (a < 10'h200) return 0;
        if (a < 10'h380) return 1;
        return 2;
    endfunction

    function automatic logic [23:0] rd_model(input logic [9:0] a);
        case (rgn_of(a))
            0:       return {8'hA1, 6'h0, a};
            1:       return {8'hB2, 6'h0, a};
            default: return {8'hC3, 6'h0, a};
        endcase
    endfunction

    function automatic logic [15:0] hdr(input logic rd, input logic [9:0] a);
        return {5'b00000, rd, a};
    endfunction

    // strobe log
    int          log_n = 0;
    logic [9:0]  log_a [8];
    logic [23:0] log_d [8];
    int          log_r [8];
    int          multi_hot = 0;

    always @(posedge clk) begin
        if ((int'(par_we) + int'(prg_we) + int'(reg_we)) > 1) multi_hot++;
        if (par_we || prg_we || reg_we) begin
            if (log_n < 8) begin
                log_a[log_n] = tgt_addr;
                log_d[log_n] = tgt_wdata;
                log_r[log_n] = par_we ? 0 : (prg_we ? 1 : 2);
            end
            log_n++;
        end
    end

    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic rx_bit [128];
    logic rx_oe  [128];

    task automatic xfer(input logic [127:0] v, input int n);
        spi_cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < n; i++) begin
            spi_mosi = v[n-1-i];
            wait_clk(HALF);
            rx_bit[i] = spi_miso;
            rx_oe[i]  = spi_miso_oe;
            spi_sclk  = 1'b1;
            wait_clk(HALF);
            spi_sclk  = 1'b0;
        end
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(6);
    endtask

    function automatic logic [23:0] rx_word(input int first);
        logic [23:0] w;
        for (int i = 0; i < 24; i++) w[23-i] = rx_bit[first+i];
        return w;
    endfunction

    typedef struct packed {
        logic [9:0]  a;
        logic [23:0] d;
        logic [1:0]  r;
    } wvec_t;

    localparam wvec_t VECS [6] = '{
        '{a: 10'h000, d: 24'h123456, r: 2'd0},
        '{a: 10'h1FF, d: 24'hFEDCBA, r: 2'd0},
        '{a: 10'h200, d: 24'h0F0F0F, r: 2'd1},
        '{a: 10'h37F, d: 24'h800001, r: 2'd1},
        '{a: 10'h380, d: 24'h5A5A5A, r: 2'd2},
        '{a: 10'h3FF, d: 24'hFFFFFF, r: 2'd2}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        // R10: reset state
        chk(!par_we && !prg_we && !reg_we, "R10 strobes", {29'b0, par_we, prg_we, reg_we}, 0);
        chk(spi_miso_oe == 1'b0, "R10 oe", spi_miso_oe, 0);
        chk(spi_miso == 1'b0, "R10 miso", spi_miso, 0);
        rst_n = 1'b1;
        wait_clk(5);

        // R1 R3 R4: single writes at region edges
        foreach (VECS[k]) begin
            log_n = 0;
            xfer({88'b0, hdr(1'b0, VECS[k].a), VECS[k].d}, 40);
            chk(log_n == 1, "R3 strobe count", log_n, 1);
            chk(log_a[0] == VECS[k].a, "R1 address", log_a[0], VECS[k].a);
            chk(log_d[0] == VECS[k].d, "R3 data", log_d[0], VECS[k].d);
            chk(log_r[0] == int'(VECS[k].r), "R4 region", log_r[0], VECS[k].r);
            chk(spi_miso_oe == 1'b0, "R9 oe after write", spi_miso_oe, 0);
        end

        // R5: continuous write wrapping past the top address
        log_n = 0;
        xfer({40'b0, hdr(1'b0, 10'h3FF), 24'hAAAAAA, 24'h555555, 24'h00C0DE}, 88);
        chk(log_n == 3, "R5 count", log_n, 3);
        chk(log_a[0] == 10'h3FF && log_r[0] == 2, "R5 first", log_a[0], 10'h3FF);
        chk(log_a[1] == 10'h000 && log_r[1] == 0, "R5 wrap", log_a[1], 10'h000);
        chk(log_d[1] == 24'h555555, "R5 data", log_d[1], 24'h555555);
        chk(log_a[2] == 10'h001 && log_d[2] == 24'h00C0DE, "R5 third", log_a[2], 10'h001);

        // R6: partial word discarded, next frame fine
        log_n = 0;
        xfer({100'b0, hdr(1'b0, 10'h010), 12'hABC}, 28);
        chk(log_n == 0, "R6 partial", log_n, 0);
        log_n = 0;
        xfer({40'b0, hdr(1'b0, 10'h020), 24'h111111, 24'h222222, 12'h333}, 76);
        chk(log_n == 2, "R6 trailing partial", log_n, 2);
        xfer({88'b0, hdr(1'b0, 10'h021), 24'h010203}, 40);
        chk(log_n == 3 && log_a[2] == 10'h021, "R6 recovery", log_a[2], 10'h021);

        // R2: nonzero pad bits on write and read
        log_n = 0;
        xfer({88'b0, 16'h8000 | hdr(1'b0, 10'h005), 24'h777777}, 40);
        chk(log_n == 0, "R2 bad write", log_n, 0);
        xfer({88'b0, 16'h0800 | hdr(1'b1, 10'h005), 24'h0}, 40);
        begin
            int seen = 0;
            for (int i = 0; i < 40; i++) if (rx_oe[i]) seen++;
            chk(seen == 0, "R2 bad read oe", seen, 0);
        end

        // R7: single read, oe timing and data
        xfer({88'b0, hdr(1'b1, 10'h123), 24'h0}, 40);
        begin
            int early = 0, late = 0;
            for (int i = 0; i < 16; i++) if (rx_oe[i]) early++;
            for (int i = 16; i < 40; i++) if (!rx_oe[i]) late++;
            chk(early == 0, "R7 oe in header", early, 0);
            chk(late == 0, "R7 oe in data", late, 0);
        end
        chk(rx_word(16) == rd_model(10'h123), "R7 read data", rx_word(16), rd_model(10'h123));
        chk(spi_miso_oe == 1'b0 && spi_miso == 1'b0, "R9 released", {spi_miso_oe, spi_miso}, 0);

        // R8: continuous read across the program/control boundary
        xfer({40'b0, hdr(1'b1, 10'h37E), 72'b0}, 88);
        chk(rx_word(16) == rd_model(10'h37E), "R8 word0", rx_word(16), rd_model(10'h37E));
        chk(rx_word(40) == rd_model(10'h37F), "R8 word1", rx_word(40), rd_model(10'h37F));
        chk(rx_word(64) == rd_model(10'h380), "R8 word2", rx_word(64), rd_model(10'h380));

        // R4: read from the parameter region edge
        xfer({88'b0, hdr(1'b1, 10'h1FF), 24'h0}, 40);
        chk(rx_word(16) == rd_model(10'h1FF), "R4 read region", rx_word(16), rd_model(10'h1FF));

        chk(multi_hot == 0, "R4 one-hot", multi_hot, 0);
        chk(spi_miso_oe == 1'b0, "R9 idle oe", spi_miso_oe, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule